// File: doc/BRIEF.md
# Auto-Negotiation Result Validator

This block supervises an Ethernet link after its auto-negotiation engine claims to have finished. The engine can report completion even though the negotiated outcome is unusable, and it does so in two silent ways. In one, a hidden status bit in the wake-on-LAN register bank is still clear when completion is reported. In the other, the expansion word says the link partner can negotiate, but the partner-ability word carries no acknowledge bit. The block samples all three status words on a valid strobe while completion is asserted. It then either accepts the result or asks the engine to negotiate again.

Each rejected result causes a one-cycle restart request. The block then waits until completion is withdrawn before it looks again. It keeps count of consecutive restarts. When the retry budget is used up and the next result is still bad, the block raises a sticky failure flag and stops asking for restarts. Clearing the negotiation enable releases the failure. While negotiation is disabled, the block does no checking, and its good flag simply follows the engine's completion flag.

Top module: `anv_validator`

## Requirements
- R1: While reset is asserted and right after it, restart_req, result_fail and retry_count are all zero, and result_good is zero while an_done is low.
- R2: While an_enable is low, result_good equals an_done in the same cycle. restart_req and result_fail stay 0 and retry_count stays 0, whatever status words are presented.
- R3: While an_enable is high and an_done is low, a stat_valid strobe causes no restart, no good flag and no change of retry_count.
- R4: A check happens on a cycle where an_enable, an_done and stat_valid are all high. If bit 12 of lpi_word is 0 at that check (late failure), restart_req is 1 in the next cycle and retry_count rises by one.
- R5: If bit 0 of exp_word is 1 and bit 14 of lpa_word is 0 at a check (early failure), restart_req is 1 in the next cycle and retry_count rises by one.
- R6: A check with bit 12 of lpi_word set passes when bit 0 of exp_word is 0, whatever bit 14 of lpa_word holds. It also passes when exp_word bit 0 and lpa_word bit 14 are both set.
- R7: restart_req lasts exactly one cycle. After it, further strobes are ignored until an_done has been seen low.
- R8: A passing check sets result_good in the next cycle and clears retry_count to 0 in that same cycle.
- R9: A failing check is the last one allowed when retry_count already equals MAX_RETRIES (6). Such a check raises result_fail in the next cycle and does not assert restart_req. result_fail then stays high and no restart is requested while an_enable is high.
- R10: Driving an_enable low clears result_fail, result_good (internal) and retry_count at the next clock edge.
- R11: result_good, once set, stays high until an_done goes low. It clears in the cycle after an_done is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| an_enable | input | 1 | Auto-negotiation enabled; low bypasses all checks |
| an_done | input | 1 | Negotiation engine reports completion |
| stat_valid | input | 1 | The three status words are valid this cycle |
| lpi_word | input | 16 | Hidden status word from the wake-on-LAN bank; bit 12 must be set |
| lpa_word | input | 16 | Link-partner ability word; bit 14 is the partner acknowledge |
| exp_word | input | 16 | Expansion word; bit 0 means the partner can negotiate |
| restart_req | output | 1 | One-cycle request to restart negotiation |
| result_good | output | 1 | Result accepted (or raw an_done when disabled) |
| result_fail | output | 1 | Sticky: retry budget exhausted |
| retry_count | output | $clog2(MAX_RETRIES+1) (3) | Consecutive restarts requested |

## Verification
Status words are presented that are clean, that are bad only through the hidden bit, and that are bad only through the missing acknowledge. Another set has the expansion capability bit clear and no acknowledge; it separates a correct expansion gate from a check that looks at the acknowledge alone. Extra strobes arrive while completion stays high after a restart, and strobes arrive while completion is low. These show whether the block waits properly between checks. A run of seven bad results followed by more attempts separates the retry limit and stickiness from a counter that wraps or keeps restarting, and toggling the enable tells the bypass and clearing paths apart.

// File: rtl/anv_pkg.sv
package anv_pkg;

  typedef enum logic [1:0] {
    ST_WAIT   = 2'd0,
    ST_DROP   = 2'd1,
    ST_GOOD   = 2'd2,
    ST_FAILED = 2'd3
  } anv_state_e;

  typedef struct packed {
    logic late_bad;
    logic early_bad;
  } anv_verdict_t;

endpackage

// File: rtl/anv_rst_sync.sv
module anv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/anv_judge.sv
module anv_judge
  import anv_pkg::*;
#(
  parameter int W       = 16,
  parameter int LPI_BIT = 12,
  parameter int CAP_BIT = 0,
  parameter int ACK_BIT = 14
) (
  input  logic [W-1:0]  lpi_word,
  input  logic [W-1:0]  lpa_word,
  input  logic [W-1:0]  exp_word,
  output anv_verdict_t  verdict,
  output logic          bad
);

  logic hidden_ok;
  logic partner_can_neg;
  logic partner_acked;
  logic unused_bits;

  assign hidden_ok       = lpi_word[LPI_BIT];
  assign partner_can_neg = exp_word[CAP_BIT];
  assign partner_acked   = lpa_word[ACK_BIT];

  always_comb begin
    verdict.late_bad  = !hidden_ok;
    verdict.early_bad = partner_can_neg && !partner_acked;
  end

  assign bad = verdict.late_bad | verdict.early_bad;

  // remaining word bits carry no meaning for the verdict
  assign unused_bits = ^{lpi_word, lpa_word, exp_word};

endmodule

// File: rtl/anv_retry_ctr.sv
module anv_retry_ctr #(
  parameter int MAX_RETRIES = 6,
  localparam int CNT_W = $clog2(MAX_RETRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             at_limit
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_RETRIES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign at_limit = (cnt_q == LIMIT);

  always_comb begin
    cnt_en = clr | (inc & ~at_limit);
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (inc && !at_limit) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/anv_seq.sv
module anv_seq
  import anv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic an_enable,
  input  logic an_done,
  input  logic stat_valid,
  input  logic bad,
  input  logic at_limit,
  output logic cnt_clr,
  output logic cnt_inc,
  output logic restart_q,
  output logic good_q,
  output logic fail_q
);

  anv_state_e st_q, st_d;
  logic       restart_d, good_d, fail_d;
  logic       flag_en;
  logic       check;

  assign check = an_done & stat_valid;

  always_comb begin
    st_d      = st_q;
    restart_d = 1'b0;
    good_d    = good_q;
    fail_d    = fail_q;
    cnt_clr   = 1'b0;
    cnt_inc   = 1'b0;
    if (!an_enable) begin
      st_d    = ST_WAIT;
      good_d  = 1'b0;
      fail_d  = 1'b0;
      cnt_clr = 1'b1;
    end else begin
      unique case (st_q)
        ST_WAIT: begin
          if (check) begin
            if (!bad) begin
              st_d    = ST_GOOD;
              good_d  = 1'b1;
              cnt_clr = 1'b1;
            end else if (at_limit) begin
              st_d   = ST_FAILED;
              fail_d = 1'b1;
            end else begin
              st_d      = ST_DROP;
              restart_d = 1'b1;
              cnt_inc   = 1'b1;
            end
          end
        end
        ST_DROP: begin
          if (!an_done) st_d = ST_WAIT;
        end
        ST_GOOD: begin
          if (!an_done) begin
            st_d   = ST_WAIT;
            good_d = 1'b0;
          end
        end
        ST_FAILED: begin
          st_d = ST_FAILED;
        end
        default: st_d = ST_WAIT;
      endcase
    end
  end

  assign flag_en = (st_d != st_q) | (good_d != good_q) | (fail_d != fail_q) |
                   (restart_d != restart_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_WAIT;
      restart_q <= 1'b0;
      good_q    <= 1'b0;
      fail_q    <= 1'b0;
    end else if (flag_en) begin
      st_q      <= st_d;
      restart_q <= restart_d;
      good_q    <= good_d;
      fail_q    <= fail_d;
    end
  end

endmodule

// File: rtl/anv_validator.sv
module anv_validator
  import anv_pkg::*;
#(
  parameter int W           = 16,
  parameter int MAX_RETRIES = 6,
  parameter int LPI_BIT     = 12,
  parameter int CAP_BIT     = 0,
  parameter int ACK_BIT     = 14,
  localparam int CNT_W      = $clog2(MAX_RETRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             an_enable,
  input  logic             an_done,
  input  logic             stat_valid,
  input  logic [W-1:0]     lpi_word,
  input  logic [W-1:0]     lpa_word,
  input  logic [W-1:0]     exp_word,
  output logic             restart_req,
  output logic             result_good,
  output logic             result_fail,
  output logic [CNT_W-1:0] retry_count
);

  logic         rst_n_int;
  anv_verdict_t verdict;
  logic         bad;
  logic         at_limit;
  logic         cnt_clr, cnt_inc;
  logic         good_q;

  anv_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  anv_judge #(
    .W(W), .LPI_BIT(LPI_BIT), .CAP_BIT(CAP_BIT), .ACK_BIT(ACK_BIT)
  ) u_judge (
    .lpi_word (lpi_word),
    .lpa_word (lpa_word),
    .exp_word (exp_word),
    .verdict  (verdict),
    .bad      (bad)
  );

  anv_retry_ctr #(.MAX_RETRIES(MAX_RETRIES)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .clr      (cnt_clr),
    .inc      (cnt_inc),
    .cnt      (retry_count),
    .at_limit (at_limit)
  );

  anv_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .an_enable  (an_enable),
    .an_done    (an_done),
    .stat_valid (stat_valid),
    .bad        (bad),
    .at_limit   (at_limit),
    .cnt_clr    (cnt_clr),
    .cnt_inc    (cnt_inc),
    .restart_q  (restart_req),
    .good_q     (good_q),
    .fail_q     (result_fail)
  );

  // bypass: with negotiation disabled the engine's flag is trusted as is
  assign result_good = an_enable ? good_q : an_done;

endmodule

// File: rtl/anv_validator_chk.sv
module anv_validator_chk #(
  parameter int MAX_RETRIES = 6,
  localparam int CNT_W      = $clog2(MAX_RETRIES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             an_enable,
  input logic             an_done,
  input logic             stat_valid,
  input logic             restart_req,
  input logic             result_good,
  input logic             result_fail,
  input logic [CNT_W-1:0] retry_count
);

  assert_restart_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |=> !restart_req);

  assert_restart_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restart_req) |-> $past(an_enable && an_done && stat_valid));

  assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (result_fail && an_enable) |=> result_fail);

  assert_fail_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    result_fail |-> !restart_req);

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retry_count <= CNT_W'(MAX_RETRIES));

  assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !an_enable |=> (!result_fail && retry_count == '0 && !restart_req));

  assert_good_fail_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    an_enable |-> !(result_good && result_fail));

endmodule

bind anv_validator anv_validator_chk #(.MAX_RETRIES(MAX_RETRIES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .an_enable   (an_enable),
  .an_done     (an_done),
  .stat_valid  (stat_valid),
  .restart_req (restart_req),
  .result_good (result_good),
  .result_fail (result_fail),
  .retry_count (retry_count)
);

// File: tb/anv_validator_tb.sv
module anv_validator_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        an_enable = 1'b0;
  logic        an_done = 1'b0;
  logic        stat_valid = 1'b0;
  logic [15:0] lpi_word = '0;
  logic [15:0] lpa_word = '0;
  logic [15:0] exp_word = '0;
  logic        restart_req, result_good, result_fail;
  logic [2:0]  retry_count;

  int    n_vec = 0;
  int    n_bad = 0;
  int    cycles = 0;
  string cur_req = "R1";

  // reference model state
  int m_st = 0;   // 0 wait, 1 drop, 2 good, 3 failed
  int m_cnt = 0;
  bit m_good = 0, m_fail = 0, m_rs = 0;

  always #2 clk = ~clk;

  anv_validator u_dut (
    .clk(clk), .rst_n(rst_n), .an_enable(an_enable), .an_done(an_done),
    .stat_valid(stat_valid), .lpi_word(lpi_word), .lpa_word(lpa_word),
    .exp_word(exp_word), .restart_req(restart_req), .result_good(result_good),
    .result_fail(result_fail), .retry_count(retry_count)
  );

  always @(posedge clk) begin
    cycles++;
    if (!rst_n || !an_enable) begin
      m_st = 0; m_cnt = 0; m_good = 0; m_fail = 0; m_rs = 0;
    end else begin
      m_rs = 0;
      if (m_st == 0) begin
        if (an_done && stat_valid) begin
          if (lpi_word[12] && !(exp_word[0] && !lpa_word[14])) begin
            m_st = 2; m_good = 1; m_cnt = 0;
          end else if (m_cnt == 6) begin
            m_st = 3; m_fail = 1;
          end else begin
            m_st = 1; m_rs = 1; m_cnt++;
          end
        end
      end else if (m_st == 1) begin
        if (!an_done) m_st = 0;
      end else if (m_st == 2) begin
        if (!an_done) begin m_st = 0; m_good = 0; end
      end
    end
  end

  always @(negedge clk) begin
    bit eg;
    eg = an_enable ? m_good : an_done;
    n_vec++;
    if (restart_req !== m_rs) begin
      n_bad++; $display("FAIL %s restart_req act=%b exp=%b", cur_req, restart_req, m_rs);
    end
    if (result_good !== eg) begin
      n_bad++; $display("FAIL %s result_good act=%b exp=%b", cur_req, result_good, eg);
    end
    if (result_fail !== m_fail) begin
      n_bad++; $display("FAIL %s result_fail act=%b exp=%b", cur_req, result_fail, m_fail);
    end
    if (retry_count !== 3'(m_cnt)) begin
      n_bad++; $display("FAIL %s retry_count act=%0d exp=%0d", cur_req, retry_count, m_cnt);
    end
  end

  always @(posedge clk) begin
    if (cycles > 20000) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp<=20000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic strobe(input logic [15:0] lpi, input logic [15:0] lpa, input logic [15:0] ex);
    stat_valid = 1'b1; lpi_word = lpi; lpa_word = lpa; exp_word = ex;
    cyc(1);
    stat_valid = 1'b0; lpi_word = '0; lpa_word = '0; exp_word = '0;
  endtask

  // one negotiation round: done rises, words arrive, optional extra strobe, done falls
  task automatic attempt(input logic [15:0] lpi, input logic [15:0] lpa,
                         input logic [15:0] ex, input bit extra);
    an_done = 1'b1; cyc(2);
    strobe(lpi, lpa, ex);
    cyc(2);
    if (extra) begin strobe(lpi, lpa, ex); cyc(1); end
    an_done = 1'b0; cyc(3);
  endtask

  initial begin
    // R1: reset state
    cur_req = "R1";
    cyc(4); rst_n = 1'b1; cyc(5);

    // R2: disabled, pass-through, bad words ignored
    cur_req = "R2";
    attempt(16'h0000, 16'h0000, 16'h0001, 1'b1);
    an_done = 1'b1; cyc(3); an_done = 1'b0; cyc(2);

    // R3: enabled, done low, strobes ignored
    cur_req = "R3";
    an_enable = 1'b1; cyc(2);
    strobe(16'h0000, 16'h0000, 16'h0001); cyc(1);
    strobe(16'h1000, 16'h4000, 16'h0001); cyc(2);

    // R6: expansion bit clear, no ack -> good
    cur_req = "R6";
    attempt(16'h1000, 16'h0000, 16'hFFFE, 1'b0);
    attempt(16'h1000, 16'h4000, 16'h0001, 1'b0);

    // R4 late failure, then R8 good clears count
    cur_req = "R4";
    attempt(16'hEFFF, 16'h4000, 16'h0001, 1'b0);
    cur_req = "R8";
    attempt(16'h1000, 16'h4000, 16'h0001, 1'b1);

    // R5 early failure; R7 extra strobe while done held
    cur_req = "R5";
    attempt(16'h1000, 16'hBFFF, 16'h0001, 1'b0);
    cur_req = "R7";
    attempt(16'h1000, 16'hBFFF, 16'h0001, 1'b1);
    cur_req = "R11";
    attempt(16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0);

    // R9: exhaust budget
    cur_req = "R9";
    for (int i = 0; i < 9; i++) attempt(16'h0000, 16'h4000, 16'h0000, 1'b1);
    attempt(16'h1000, 16'h4000, 16'h0001, 1'b0);

    // R10: disable releases failure
    cur_req = "R10";
    an_enable = 1'b0; cyc(3);
    an_enable = 1'b1; cyc(2);
    attempt(16'h0000, 16'h0000, 16'h0001, 1'b0);
    cur_req = "R2";
    an_enable = 1'b0; an_done = 1'b1; cyc(2); an_done = 1'b0; cyc(2);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule